// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers the reset requests of a microcontroller-class chip into one system reset and runs the sequence that leaves reset. Seven requesters feed it: the supply monitor, the bidirectional active-low reset pin, a conversion-start strobe, a software request, a comparator output, a missing-clock one-shot and a watchdog timeout. The comparator and conversion-start requests count only when their own enable input is high. The pin and the comparator output each pass through a two-flop synchroniser. A loss of supply clears the whole block at once. The core reset output falls without waiting for a clock edge in that case, and it always rises on a clock edge.

After a supply event the controller holds the reset pin low for a programmable number of clock cycles. It then keeps the core in reset until every request has ended, with a minimum hold of a few cycles. The block then leaves reset and enables the port pull-ups and the watchdog at its longest interval. It keeps the core held until the clock source is reported stable, and then releases the core with a one-cycle fetch-start strobe. During reset the port latches are preset to all ones, the pull-ups are off, and the interrupt, timer and stack-pointer hold is active. A cause register records which requests began the most recent reset.

Top module: `rst_funnel_ctrl`

## Requirements
- R1: While `supply_ok` is low, `core_rst_n` is low without waiting for a clock edge and `rst_cause` equals 7'b0000001. After `supply_ok` rises, `rst_pin_drive_low` stays high for between SUPPLY_TMO and SUPPLY_TMO+3 cycles, and then falls.
- R2: A low level on `rst_pin_in` while the block is not itself driving the pin puts the core in reset, and sets `rst_cause` bit 1 alone.
- R3: A high `cnv_strobe` puts the core in reset and sets `rst_cause` bit 2 only while `cnv_rst_en` is 1. While `cnv_rst_en` is 0 it causes no reset and leaves `rst_cause` unchanged.
- R4: A high `cmp_out` puts the core in reset and sets `rst_cause` bit 4 only while `cmp_rst_en` is 1. While `cmp_rst_en` is 0 it causes no reset and leaves `rst_cause` unchanged.
- R5: A one-cycle `sw_rst_req` pulse drives `core_rst_n` low from the next cycle, keeps it low for at least 4 cycles, and sets `rst_cause` bit 3 alone.
- R6: A one-cycle `mclk_fire` pulse resets the core and sets `rst_cause` bit 5 alone. A one-cycle `wdt_timeout` pulse resets the core and sets `rst_cause` bit 6 alone.
- R7: While a reset is held, every bit of `port_preset` is 1, `pullup_en` is 0 and `periph_hold` is 1. Once the requests end, `pullup_en` rises while the core is still waiting for the clock.
- R8: After the reset is left, `wdt_en` is 1 and `wdt_prescale` is all ones (its longest interval). `clk_sel_int` stays 1, selecting the internal oscillator, until the core runs.
- R9: `core_rst_n` rises only after `clk_stable` is 1. `fetch_start` is high for exactly one cycle, in the first cycle with `core_rst_n` high.
- R10: `rst_cause` keeps the sources of the most recent reset until the next reset. A supply loss clears every other bit of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Supply monitor flag; low means power-on or supply fail |
| rst_pin_in | input | 1 | Level seen on the active-low reset pin |
| rst_pin_drive_low | output | 1 | Open-drain pull-down enable for the reset pin |
| cnv_strobe | input | 1 | Conversion-start strobe request |
| cnv_rst_en | input | 1 | Lets the conversion-start strobe cause a reset |
| cmp_out | input | 1 | Comparator output request |
| cmp_rst_en | input | 1 | Lets the comparator cause a reset |
| sw_rst_req | input | 1 | Single-cycle software reset request |
| mclk_fire | input | 1 | Missing-clock one-shot pulse |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| clk_stable | input | 1 | Clock source reports stable |
| core_rst_n | output | 1 | Active-low core reset |
| fetch_start | output | 1 | One-cycle strobe: core starts fetching at address 0 |
| port_preset | output | NPORTS | Per port: force output latch to all ones |
| pullup_en | output | 1 | Weak pull-up enable |
| periph_hold | output | 1 | Holds interrupt enables and timer runs off, reloads stack pointer |
| wdt_en | output | 1 | Watchdog enable default |
| wdt_prescale | output | PS_W | Watchdog interval default |
| clk_sel_int | output | 1 | Selects the internal oscillator |
| rst_cause | output | 7 | Source flags of the last reset (bit 0 supply, 1 pin, 2 conversion, 3 software, 4 comparator, 5 missing clock, 6 watchdog) |

## Verification
The main function is tried with a one-cycle pulse from each requester in turn. The result tells whether the right cause bit alone is recorded and whether the pin and comparator synchronisers pass a short event. The gated requesters are each pulsed once with the enable high and once with it low. The disabled case must show no reset cycle and an unchanged cause. A power-up with the clock still unstable, followed by the clock becoming stable, separates the state where reset has been left from the state where the core runs.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int NSRC       = 7;
  localparam int SRC_SUPPLY = 0;
  localparam int SRC_PIN    = 1;
  localparam int SRC_CNV    = 2;
  localparam int SRC_SW     = 3;
  localparam int SRC_CMP    = 4;
  localparam int SRC_MCLK   = 5;
  localparam int SRC_WDT    = 6;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_CLKWAIT = 2'd1,
    ST_RUN     = 2'd2
  } rst_state_e;
endpackage

// File: rtl/rfc_sync2.sv
module rfc_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d};
  end

  assign q = ff_q[1];
endmodule

// File: rtl/rfc_supply_timer.sv
module rfc_supply_timer #(
  parameter int TMO = 200000
) (
  input  logic clk,
  input  logic arst_n,
  output logic busy
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == CW'(TMO - 1)) busy_d = 1'b0;
      else                       cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/rfc_funnel.sv
module rfc_funnel
  import rfc_pkg::*;
#(
  parameter int MIN_RST = 4
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            supply_busy,
  input  logic            pin_low_s,
  input  logic            cnv,
  input  logic            cnv_en,
  input  logic            sw,
  input  logic            cmp_s,
  input  logic            cmp_en,
  input  logic            mclk,
  input  logic            wdt,
  input  logic            in_hold,
  output logic            active,
  output logic [NSRC-1:0] cause
);
  localparam int HW = (MIN_RST > 2) ? $clog2(MIN_RST) : 1;

  logic [NSRC-1:0] req;
  logic            any_req;
  logic [HW-1:0]   hold_q, hold_d;
  logic [NSRC-1:0] cause_q, cause_d;

  // the pin reads low while this block pulls it, so mask it then
  assign req[SRC_SUPPLY] = supply_busy;
  assign req[SRC_PIN]    = pin_low_s & ~supply_busy;
  assign req[SRC_CNV]    = cnv & cnv_en;
  assign req[SRC_SW]     = sw;
  assign req[SRC_CMP]    = cmp_s & cmp_en;
  assign req[SRC_MCLK]   = mclk;
  assign req[SRC_WDT]    = wdt;

  assign any_req = |req;

  always_comb begin
    hold_d = hold_q;
    if (any_req)              hold_d = HW'(MIN_RST - 1);
    else if (hold_q != '0)    hold_d = hold_q - 1'b1;
  end

  always_comb begin
    cause_d = cause_q;
    if (any_req && !in_hold) cause_d = req;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q  <= '0;
      cause_q <= NSRC'(1) << SRC_SUPPLY;
    end else begin
      hold_q  <= hold_d;
      cause_q <= cause_d;
    end
  end

  assign active = any_req | (hold_q != '0);
  assign cause  = cause_q;
endmodule

// File: rtl/rst_funnel_ctrl.sv
module rst_funnel_ctrl
  import rfc_pkg::*;
#(
  parameter int SUPPLY_TMO = 200000,
  parameter int MIN_RST    = 4,
  parameter int NPORTS     = 4,
  parameter int PS_W       = 3
) (
  input  logic              clk,
  input  logic              supply_ok,
  input  logic              rst_pin_in,
  output logic              rst_pin_drive_low,
  input  logic              cnv_strobe,
  input  logic              cnv_rst_en,
  input  logic              cmp_out,
  input  logic              cmp_rst_en,
  input  logic              sw_rst_req,
  input  logic              mclk_fire,
  input  logic              wdt_timeout,
  input  logic              clk_stable,
  output logic              core_rst_n,
  output logic              fetch_start,
  output logic [NPORTS-1:0] port_preset,
  output logic              pullup_en,
  output logic              periph_hold,
  output logic              wdt_en,
  output logic [PS_W-1:0]   wdt_prescale,
  output logic              clk_sel_int,
  output logic [NSRC-1:0]   rst_cause
);
  logic [1:0] por_q;
  logic       arst_n;
  logic       supply_busy;
  logic       pin_s;
  logic       cmp_s;
  logic       active;
  rst_state_e state_q, state_d;
  logic       fetch_q, fetch_d;

  // supply loss clears at once; release follows two clock edges
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) por_q <= 2'b00;
    else            por_q <= {por_q[0], 1'b1};
  end
  assign arst_n = por_q[1];

  rfc_supply_timer #(.TMO(SUPPLY_TMO)) u_tmr (
    .clk(clk), .arst_n(arst_n), .busy(supply_busy)
  );

  rfc_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(arst_n), .d(rst_pin_in), .q(pin_s)
  );

  rfc_sync2 #(.RST_VAL(1'b0)) u_cmp_sync (
    .clk(clk), .arst_n(arst_n), .d(cmp_out), .q(cmp_s)
  );

  rfc_funnel #(.MIN_RST(MIN_RST)) u_funnel (
    .clk(clk), .arst_n(arst_n), .supply_busy(supply_busy),
    .pin_low_s(~pin_s), .cnv(cnv_strobe), .cnv_en(cnv_rst_en),
    .sw(sw_rst_req), .cmp_s(cmp_s), .cmp_en(cmp_rst_en),
    .mclk(mclk_fire), .wdt(wdt_timeout), .in_hold(state_q == ST_HOLD),
    .active(active), .cause(rst_cause)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HOLD:    if (!active) state_d = ST_CLKWAIT;
      ST_CLKWAIT: if (active) state_d = ST_HOLD;
                  else if (clk_stable) state_d = ST_RUN;
      ST_RUN:     if (active) state_d = ST_HOLD;
      default:    state_d = ST_HOLD;
    endcase
  end

  assign fetch_d = (state_q == ST_CLKWAIT) && !active && clk_stable;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_HOLD;
      fetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fetch_q <= fetch_d;
    end
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign port_preset[p] = (state_q != ST_RUN);
    end
  endgenerate

  assign rst_pin_drive_low = supply_busy;
  assign core_rst_n        = (state_q == ST_RUN);
  assign fetch_start       = fetch_q;
  assign pullup_en         = (state_q != ST_HOLD);
  assign periph_hold       = (state_q != ST_RUN);
  assign wdt_en            = (state_q != ST_HOLD);
  assign wdt_prescale      = wdt_en ? {PS_W{1'b1}} : '0;
  assign clk_sel_int       = (state_q != ST_RUN);
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              arst_n,
  input logic              core_rst_n,
  input logic              rst_pin_drive_low,
  input logic              sw_rst_req,
  input logic              wdt_timeout,
  input logic              clk_stable,
  input logic              fetch_start,
  input logic              pullup_en,
  input logic [NPORTS-1:0] port_preset
);
  // R1
  pin_drive_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_pin_drive_low |-> !core_rst_n);
  // R5
  sw_enters_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sw_rst_req |=> !core_rst_n);
  // R6
  wdt_enters_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_timeout |=> !core_rst_n);
  // R7
  preset_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !core_rst_n |-> (&port_preset));
  // R7
  pullup_off_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pullup_en |-> !core_rst_n);
  // R9
  fetch_after_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    fetch_start |-> (core_rst_n && $past(clk_stable)));
  // R9
  fetch_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    fetch_start |=> !fetch_start);
endmodule

bind rst_funnel_ctrl rfc_checker #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .arst_n(arst_n), .core_rst_n(core_rst_n),
  .rst_pin_drive_low(rst_pin_drive_low), .sw_rst_req(sw_rst_req),
  .wdt_timeout(wdt_timeout), .clk_stable(clk_stable),
  .fetch_start(fetch_start), .pullup_en(pullup_en), .port_preset(port_preset)
);

// File: tb/rst_funnel_ctrl_tb.sv
`timescale 1ns/1ps
module rst_funnel_ctrl_tb;
  localparam int TMO    = 20;
  localparam int NPORTS = 4;
  localparam int PS_W   = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic supply_ok = 1'b0, ext_low = 1'b0;
  logic cnv = 1'b0, cnv_en = 1'b0, cmp = 1'b0, cmp_en = 1'b0;
  logic sw = 1'b0, mclk = 1'b0, wdt = 1'b0, stable = 1'b0;
  logic drive_low, core_rst_n, fetch_start, pullup_en, periph_hold;
  logic wdt_en, clk_sel_int;
  logic [NPORTS-1:0] port_preset;
  logic [PS_W-1:0]   wdt_prescale;
  logic [6:0]        rst_cause;
  wire               pin = ~(drive_low | ext_low);

  int checks = 0, failures = 0;
  bit done = 1'b0;

  rst_funnel_ctrl #(.SUPPLY_TMO(TMO), .MIN_RST(4), .NPORTS(NPORTS), .PS_W(PS_W)) u_dut (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_in(pin), .rst_pin_drive_low(drive_low),
    .cnv_strobe(cnv), .cnv_rst_en(cnv_en), .cmp_out(cmp), .cmp_rst_en(cmp_en),
    .sw_rst_req(sw), .mclk_fire(mclk), .wdt_timeout(wdt), .clk_stable(stable),
    .core_rst_n(core_rst_n), .fetch_start(fetch_start), .port_preset(port_preset),
    .pullup_en(pullup_en), .periph_hold(periph_hold), .wdt_en(wdt_en),
    .wdt_prescale(wdt_prescale), .clk_sel_int(clk_sel_int), .rst_cause(rst_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind[4:2] (1 pin,2 cnv,3 sw,4 cmp,5 mclk,6 wdt), enable[1], reset expected[0]
  localparam logic [4:0] VEC [0:7] = '{
    {3'd1, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b1}, {3'd2, 1'b0, 1'b0}, {3'd3, 1'b1, 1'b1},
    {3'd4, 1'b1, 1'b1}, {3'd4, 1'b0, 1'b0}, {3'd5, 1'b1, 1'b1}, {3'd6, 1'b1, 1'b1}
  };

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp_cause;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 R7 reset state with supply low
    check("R1 core_rst_n in supply loss", core_rst_n, 0);
    check("R1 cause power-on", rst_cause, 7'b0000001);
    check("R7 port preset", port_preset, {NPORTS{1'b1}});
    check("R7 pullup off", pullup_en, 0);
    check("R7 periph hold", periph_hold, 1);
    supply_ok = 1'b1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (drive_low) cnt++;
    end
    check("R1 pin drive window", (cnt >= TMO && cnt <= TMO + 3), 1);
    check("R1 pin released", drive_low, 0);
    // R7 R8 R9 waiting for clock
    check("R9 held while clock unstable", core_rst_n, 0);
    check("R7 pullup after exit", pullup_en, 1);
    check("R8 wdt enabled", wdt_en, 1);
    check("R8 wdt longest interval", wdt_prescale, {PS_W{1'b1}});
    check("R8 internal oscillator", clk_sel_int, 1);
    stable = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fetch_start) begin
        cnt++;
        check("R9 fetch with core released", core_rst_n, 1);
      end
    end
    check("R9 single fetch strobe", cnt, 1);
    check("R9 core running", core_rst_n, 1);
    check("R8 clk select after run", clk_sel_int, 0);

    exp_cause = 7'b0000001;
    for (int v = 0; v < 8; v++) begin
      int kind;
      logic en, exp_rst;
      kind = int'(VEC[v][4:2]);
      en = VEC[v][1];
      exp_rst = VEC[v][0];
      cnv_en = (kind == 2) ? en : 1'b0;
      cmp_en = (kind == 4) ? en : 1'b0;
      ext_low = (kind == 1);
      cnv = (kind == 2);
      sw = (kind == 3);
      cmp = (kind == 4);
      mclk = (kind == 5);
      wdt = (kind == 6);
      @(negedge clk);
      {ext_low, cnv, sw, cmp, mclk, wdt} = '0;
      cnt = 0;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        if (!core_rst_n) cnt++;
      end
      if (exp_rst) exp_cause = 7'(1) << kind;
      // R2 R3 R4 R5 R6 R10 per source
      check($sformatf("R2 R3 R4 R5 R6 reset kind %0d en %0d", kind, en), (cnt > 0), exp_rst);
      check($sformatf("R10 cause kind %0d en %0d", kind, en), rst_cause, exp_cause);
      check($sformatf("R9 back running kind %0d", kind), core_rst_n, 1);
    end

    // R5 minimum duration of a software reset
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!core_rst_n) cnt++;
    end
    check("R5 sw reset length >= 4", (cnt >= 4), 1);
    check("R5 sw cause", rst_cause, 7'b0001000);

    // R1 R10 supply loss mid-run clears other flags
    #1.0 supply_ok = 1'b0;
    #0.5;
    check("R1 async core reset", core_rst_n, 0);
    @(negedge clk);
    check("R10 power-on clears flags", rst_cause, 7'b0000001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule